// File: doc/BRIEF.md
# USB Remote Wakeup Sequencer

This block governs how a USB device leaves its low-power state and how it drives upstream resume signalling. Software controls it through three level inputs: a power-down request, a remote-wakeup request and a host-wake enable. The block drives an oscillator enable. For each wake it waits on an oscillator-stable input, watches the synchronised D+/D− line state and counts ticks of a millisecond timebase.

The block can wake in three ways. Software can drop the power-down request, software can raise the remote-wakeup request, or the host can pull D+ low while host wake is enabled. A chip reset also wakes it. Every wake turns the oscillator back on and then waits for the stable indication. A remote wakeup then goes further. The block waits until the bus has been continuously idle (J state) for a set number of ticks. It then drives a K state for a fixed number of ticks, timing the interval itself. When the K state ends it raises a sticky completion flag.

Top module: `usb_rwake_seq`

## Requirements
- R1: After an asynchronous reset, osc_en_o is 1, k_drive_o is 0 and rwu_done_o is 0.
- R2: While power-down is permitted, a high pwrdown_i puts the block to sleep, and osc_en_o is 0 from the next cycle. Power-down is permitted once pwrdown_i has been seen low since the last reset or the last remote/host wake.
- R3: While asleep, pwrdown_i high, and sigrwu_i rising (armed), osc_en_o returns to 1 on the next cycle. k_drive_o stays 0 for as long as osc_stable_i is low.
- R4: k_drive_o rises only after IDLE_TICKS consecutive tick_i pulses counted while the line is idle (dp_i=1, dm_i=0) with the oscillator stable. Any non-idle cycle restarts the count from zero.
- R5: k_drive_o stays high for exactly K_TICKS tick_i pulses and then falls.
- R6: rwu_done_o goes to 1 in the same cycle that k_drive_o falls at the end of the K interval.
- R7: rwu_done_o holds until a done_clr_i pulse clears it. A completion in the same cycle as a clear wins.
- R8: The remote-wakeup request is armed only after sigrwu_i has been low. A sigrwu_i held high since the last sequence does not wake the block again.
- R9: While asleep with pwrdown_i high and hwake_en_i=1, a 1-to-0 change of dp_i raises osc_en_o on the next cycle. After osc_stable_i the block returns to awake without driving K. With hwake_en_i=0 the edge is ignored.
- R10: Dropping pwrdown_i while asleep, or an asynchronous reset, raises osc_en_o. After a reset the block stays awake while pwrdown_i stays high, until pwrdown_i has been low once.
- R11: A permitted power-down during the oscillator wait, the idle count or the K state drops osc_en_o and k_drive_o on the next cycle and discards the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous chip reset |
| pwrdown_i | input | 1 | Power-down request |
| sigrwu_i | input | 1 | Remote-wakeup request |
| hwake_en_i | input | 1 | Enable wake on D+ falling edge |
| dp_i | input | 1 | Synchronised D+ |
| dm_i | input | 1 | Synchronised D− |
| osc_stable_i | input | 1 | Oscillator stable indication |
| tick_i | input | 1 | Millisecond timebase pulse |
| done_clr_i | input | 1 | Clear pulse for the completion flag |
| osc_en_o | output | 1 | Oscillator enable |
| k_drive_o | output | 1 | Drive K state on the bus |
| rwu_done_o | output | 1 | Sticky remote-wakeup-done flag |

## Verification
A wrong sequencer state is visible at the ports within one clock. An early or missed transition flips osc_en_o or k_drive_o on the next cycle, so per-cycle comparison against a reference model catches it. A fault in the tick counter, such as an off-by-one limit or a count that is not cleared on a non-idle line, shows as a K edge shifted by one or more ticks. A lost arm or permit bit shows as a spurious or missing wake, which appears on osc_en_o one cycle after the stimulus.

// File: rtl/rwake_pkg.sv
package rwake_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE,
    ST_SLEEP,
    ST_OSC,
    ST_IDLE,
    ST_KSTATE
  } rwake_state_e;
endpackage

// File: rtl/rwake_tick_cnt.sv
module rwake_tick_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = inc_i && (cnt_q == (limit_i - W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/rwake_wake_det.sv
module rwake_wake_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dp_i,
  input  logic sigrwu_i,
  input  logic consume_i,
  output logic dp_fall_o,
  output logic rwu_armed_o
);
  logic dp_q, arm_q;

  // reset low so a low line after reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      dp_q <= dp_i;
      if (!sigrwu_i)      arm_q <= 1'b1;
      else if (consume_i) arm_q <= 1'b0;
    end
  end

  assign dp_fall_o   = dp_q & ~dp_i;
  assign rwu_armed_o = arm_q & sigrwu_i;
endmodule

// File: rtl/usb_rwake_seq.sv
module usb_rwake_seq
  import rwake_pkg::*;
#(
  parameter int IDLE_TICKS = 5,
  parameter int K_TICKS    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdown_i,
  input  logic sigrwu_i,
  input  logic hwake_en_i,
  input  logic dp_i,
  input  logic dm_i,
  input  logic osc_stable_i,
  input  logic tick_i,
  input  logic done_clr_i,
  output logic osc_en_o,
  output logic k_drive_o,
  output logic rwu_done_o
);
  localparam int MAX_T = (IDLE_TICKS > K_TICKS) ? IDLE_TICKS : K_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  rwake_state_e state_q, state_d;
  logic src_rwu_q, src_rwu_d;
  logic pd_ok_q, done_q;
  logic line_idle, sleep_req, dp_fall, rwu_armed;
  logic rwu_go, host_go, cnt_clr, cnt_inc, cnt_hit, k_end;
  logic [CNT_W-1:0] cnt_limit;

  assign line_idle = dp_i & ~dm_i;
  assign sleep_req = pwrdown_i & pd_ok_q;
  assign rwu_go    = (state_q == ST_SLEEP) && pwrdown_i && rwu_armed;
  assign host_go   = (state_q == ST_SLEEP) && pwrdown_i && !rwu_armed
                     && hwake_en_i && dp_fall;

  rwake_wake_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dp_i       (dp_i),
    .sigrwu_i   (sigrwu_i),
    .consume_i  (rwu_go),
    .dp_fall_o  (dp_fall),
    .rwu_armed_o(rwu_armed)
  );

  assign cnt_limit = (state_q == ST_KSTATE) ? CNT_W'(K_TICKS) : CNT_W'(IDLE_TICKS);
  assign cnt_inc   = tick_i && (((state_q == ST_IDLE) && line_idle) || (state_q == ST_KSTATE));
  assign cnt_clr   = (state_d != state_q) || ((state_q == ST_IDLE) && !line_idle);

  rwake_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .limit_i(cnt_limit),
    .hit_o  (cnt_hit)
  );

  always_comb begin
    state_d   = state_q;
    src_rwu_d = src_rwu_q;
    k_end     = 1'b0;
    unique case (state_q)
      ST_AWAKE: if (sleep_req) state_d = ST_SLEEP;
      ST_SLEEP: begin
        if (!pwrdown_i || rwu_go || host_go) begin
          state_d   = ST_OSC;
          src_rwu_d = rwu_go;
        end
      end
      ST_OSC: begin
        if (sleep_req)         state_d = ST_SLEEP;
        else if (osc_stable_i) state_d = src_rwu_q ? ST_IDLE : ST_AWAKE;
      end
      ST_IDLE: begin
        if (sleep_req)    state_d = ST_SLEEP;
        else if (cnt_hit) state_d = ST_KSTATE;
      end
      ST_KSTATE: begin
        if (sleep_req) state_d = ST_SLEEP;
        else if (cnt_hit) begin
          state_d = ST_AWAKE;
          k_end   = 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_AWAKE;
      src_rwu_q <= 1'b0;
      pd_ok_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      src_rwu_q <= src_rwu_d;
      if (!pwrdown_i)              pd_ok_q <= 1'b1;
      else if (rwu_go || host_go)  pd_ok_q <= 1'b0;
      if (k_end)           done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign osc_en_o   = (state_q != ST_SLEEP);
  assign k_drive_o  = (state_q == ST_KSTATE);
  assign rwu_done_o = done_q;
endmodule

// File: rtl/usb_rwake_seq_chk.sv
module usb_rwake_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwrdown_i,
  input logic sigrwu_i,
  input logic hwake_en_i,
  input logic dp_i,
  input logic dm_i,
  input logic tick_i,
  input logic done_clr_i,
  input logic osc_en_o,
  input logic k_drive_o,
  input logic rwu_done_o
);
  // R11
  k_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_drive_o |-> osc_en_o);
  // R4
  k_after_idle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(k_drive_o) |-> $past(dp_i && !dm_i && tick_i));
  // R6
  done_at_k_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rwu_done_o) |-> $fell(k_drive_o));
  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rwu_done_o && !done_clr_i) |=> rwu_done_o);
  // R2
  sleep_on_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(pwrdown_i));
  // R3
  wake_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> $past(!pwrdown_i || sigrwu_i || hwake_en_i));
endmodule

bind usb_rwake_seq usb_rwake_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwrdown_i (pwrdown_i),
  .sigrwu_i  (sigrwu_i),
  .hwake_en_i(hwake_en_i),
  .dp_i      (dp_i),
  .dm_i      (dm_i),
  .tick_i    (tick_i),
  .done_clr_i(done_clr_i),
  .osc_en_o  (osc_en_o),
  .k_drive_o (k_drive_o),
  .rwu_done_o(rwu_done_o)
);

// File: tb/sim_usb_rwake_seq.sv
module sim_usb_rwake_seq;
  localparam int CLK_NS = 10;
  localparam int IDLE_T = 5;
  localparam int K_T    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwrdown = 1'b0, sig = 1'b0, hwen = 1'b0, dp = 1'b1, dm = 1'b0;
  logic stable = 1'b1, tick = 1'b0, clr = 1'b0;
  logic osc_en, k_drv, done;
  int n_run = 0, n_fail = 0;

  usb_rwake_seq #(.IDLE_TICKS(IDLE_T), .K_TICKS(K_T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwrdown_i(pwrdown), .sigrwu_i(sig),
    .hwake_en_i(hwen), .dp_i(dp), .dm_i(dm), .osc_stable_i(stable),
    .tick_i(tick), .done_clr_i(clr), .osc_en_o(osc_en), .k_drive_o(k_drv),
    .rwu_done_o(done)
  );

  always #(CLK_NS/2) clk = ~clk;

  // reference model: 0 awake, 1 sleep, 2 osc wait, 3 idle count, 4 K state
  int m_mode, m_cnt;
  bit m_rwu, m_pdok, m_arm, m_dpq, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_rwu = 0; m_pdok = 0; m_arm = 0; m_dpq = 0; m_done = 0;
    end else begin
      automatic bit sreq = pwrdown && m_pdok;
      automatic bit rgo  = (m_mode == 1) && pwrdown && sig && m_arm;
      automatic bit hgo  = (m_mode == 1) && pwrdown && !rgo && hwen && m_dpq && !dp;
      automatic int nm   = m_mode;
      automatic bit ndone = m_done && !clr;
      if (m_mode == 0) begin
        if (sreq) nm = 1;
      end else if (m_mode == 1) begin
        if (!pwrdown || rgo || hgo) begin nm = 2; m_rwu = rgo; end
      end else if (sreq) begin
        nm = 1;
      end else if (m_mode == 2) begin
        if (stable) nm = m_rwu ? 3 : 0;
      end else if (m_mode == 3) begin
        if (!(dp && !dm)) m_cnt = 0;
        else if (tick) begin
          m_cnt++;
          if (m_cnt == IDLE_T) nm = 4;
        end
      end else begin
        if (tick) begin
          m_cnt++;
          if (m_cnt == K_T) begin nm = 0; ndone = 1; end
        end
      end
      if (nm != m_mode) m_cnt = 0;
      m_mode = nm;
      m_done = ndone;
      if (!pwrdown) m_pdok = 1; else if (rgo || hgo) m_pdok = 0;
      if (!sig) m_arm = 1; else if (rgo) m_arm = 0;
      m_dpq = dp;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_run++;
      if (osc_en !== (m_mode != 1) || k_drv !== (m_mode == 4) || done !== m_done) begin
        n_fail++;
        $display("FAIL R2/R4/R6 model: osc=%0b k=%0b done=%0b expected osc=%0b k=%0b done=%0b",
                 osc_en, k_drv, done, m_mode != 1, m_mode == 4, m_done);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 osc", osc_en, 1'b1);
    chk("R1 k", k_drv, 1'b0);
    chk("R1 done", done, 1'b0);

    pwrdown = 1; step(1);
    chk("R2 sleep", osc_en, 1'b0);
    stable = 0;

    sig = 1; tick = 1; step(1);
    chk("R3 osc on", osc_en, 1'b1);
    step(6);
    chk("R3 no K before stable", k_drv, 1'b0);
    stable = 1; step(5);
    chk("R4 before idle window", k_drv, 1'b0);
    step(1);
    chk("R4 K starts", k_drv, 1'b1);
    step(9);
    chk("R5 K held", k_drv, 1'b1);
    step(1);
    chk("R5 K ends", k_drv, 1'b0);
    chk("R6 done set", done, 1'b1);
    tick = 0; step(3);
    chk("R7 sticky", done, 1'b1);
    clr = 1; step(1); clr = 0;
    chk("R7 cleared", done, 1'b0);
    step(3);
    chk("R10 stay awake until pd low", osc_en, 1'b1);

    pwrdown = 0; step(1); pwrdown = 1; step(1);
    chk("R2 sleep again", osc_en, 1'b0);
    step(4);
    chk("R8 held request ignored", osc_en, 1'b0);
    sig = 0; step(1); sig = 1; step(1);
    chk("R8 rearmed wake", osc_en, 1'b1);
    step(1);
    tick = 1; step(3);
    dp = 0; step(1); dp = 1;
    step(4);
    chk("R4 count restarted", k_drv, 1'b0);
    step(1);
    chk("R4 K after restart", k_drv, 1'b1);
    step(10);
    chk("R5 K over", k_drv, 1'b0);
    tick = 0; clr = 1; step(1); clr = 0;

    pwrdown = 0; step(1); pwrdown = 1; step(1);
    sig = 0; step(1); sig = 1; step(1); step(1);
    tick = 1; step(2);
    pwrdown = 0; step(1); pwrdown = 1; step(1);
    chk("R11 abort osc", osc_en, 1'b0);
    chk("R11 abort k", k_drv, 1'b0);
    step(10);
    chk("R11 no K", k_drv, 1'b0);
    tick = 0;

    dp = 0; step(1);
    chk("R9 edge ignored", osc_en, 1'b0);
    dp = 1; step(1); hwen = 1; dp = 0; step(1);
    chk("R9 host wake", osc_en, 1'b1);
    step(2);
    chk("R9 no K", k_drv, 1'b0);
    dp = 1; hwen = 0;

    pwrdown = 0; step(1); pwrdown = 1; step(1);
    chk("R2 sleep before clear", osc_en, 1'b0);
    stable = 0; pwrdown = 0; step(1);
    chk("R10 clear wakes", osc_en, 1'b1);
    step(3); stable = 1; step(1);
    pwrdown = 1; step(1);
    chk("R2 sleep before reset", osc_en, 1'b0);
    rst_n = 0; #1;
    chk("R10 reset wakes", osc_en, 1'b1);
    step(1); rst_n = 1; step(2);
    chk("R10 stay awake after reset", osc_en, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule